// File: doc/BRIEF.md
# Accumulator-Index Register File

This unit keeps the working registers of a small 8-bit processor core: an accumulator, two index registers and a stack pointer. It carries out the one-byte moves between these registers and loads any of the three data registers from an immediate byte. It also exposes the index-high and accumulator-low registers together as one 16-bit word, and that word can be written in a single operation.

The sequencer that drives the unit presents a decoded operation code on `op` and pulses `start`. The accepted operation writes its destination register on the clock edge that accepts it. The unit then holds `busy` high for as many cycles as the operation would occupy on the bus and reports that number on `cycles_out`. Once those cycles have passed, it raises `done` for one cycle. If the operation changes the sign and zero flags, `flag_we` is high in that same cycle, and the new values are on `flag_n` and `flag_z`.

The operation codes are fixed: 0 idle, 1 load A, 2 load X, 3 load Y, 4 A←X, 5 A←Y, 6 X←A, 7 Y←A, 8 X←SP, 9 SP←X, 10 write the YA word. Codes 11 to 15 behave like code 0.

Top module: `acc_idx_regs`

## Requirements
- R1: While `rst` is high and after it falls, A, X and Y read 0, SP reads `SP_INIT` (default 8'hFF), and `busy` and `done` are low.
- R2: Codes 1, 2 and 3 load `imm` into A, X and Y. Each occupies 2 cycles and updates the flags.
- R3: Code 4 copies X into A, code 5 copies Y into A, code 6 copies A into X, code 7 copies A into Y and code 8 copies SP into X. Each occupies 2 cycles and updates the flags from the copied byte.
- R4: Code 9 copies X into SP, occupies 2 cycles, and leaves `flag_we` low when it completes.
- R5: For byte results, `flag_n` equals bit 7 of the result and `flag_z` is 1 exactly when the result is 8'h00.
- R6: `pair_ya` always shows Y in bits 15:8 and A in bits 7:0. Code 10 writes `word_in[7:0]` to A and `word_in[15:8]` to Y and occupies 2 cycles. Its flags are N = bit 15 of the word and Z = (word == 0).
- R7: A `start` seen while `busy` is low is accepted, and the destination changes on that same edge. `busy` then stays high for exactly `cycles_out` cycles, after which `done` is high for one cycle. `flag_we` can be high only together with `done`.
- R8: A `start` seen while `busy` is high is ignored. No register changes, and the current operation's timing and flags are unaffected.
- R9: Code 0 and codes 11 to 15 change no register, occupy 1 cycle, and leave `flag_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation request strobe |
| op | input | 4 | Operation code |
| imm | input | 8 | Immediate or load-data byte |
| word_in | input | 16 | Word for the YA write |
| reg_a | output | 8 | Accumulator |
| reg_x | output | 8 | Index X |
| reg_y | output | 8 | Index Y |
| reg_sp | output | 8 | Stack pointer |
| pair_ya | output | 16 | Y:A word view |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cycles_out | output | 4 | Cycle count of the accepted operation |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |
| flag_we | output | 1 | Flag update enable, with `done` |

## Verification
Immediate loads use bytes with bit 7 set, zero and 8'h7F. Each pattern separates the sign and zero rules from each other. The code 10 word write uses 16'h8001 and 16'h0000. These show which byte lands in which register, and they show that the flags come from the whole word rather than from one byte. A chain of transfers passes one value through each path, so a swapped source or destination shows up in a later register value. A strobe sent during a busy window, followed by idle and undefined codes, separates accepted work from ignored work and 1-cycle timing from 2-cycle timing.

// File: rtl/acc_idx_pkg.sv
package acc_idx_pkg;

    localparam int OP_W  = 4;
    localparam int CYC_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 4'd0,
        OP_LDI_A   = 4'd1,
        OP_LDI_X   = 4'd2,
        OP_LDI_Y   = 4'd3,
        OP_A_X     = 4'd4,
        OP_A_Y     = 4'd5,
        OP_X_A     = 4'd6,
        OP_Y_A     = 4'd7,
        OP_X_SP    = 4'd8,
        OP_SP_X    = 4'd9,
        OP_PAIR_WR = 4'd10
    } op_e;

    // Destination order matches register bank slot index plus one.
    typedef enum logic [2:0] {
        DST_NONE = 3'd0,
        DST_A    = 3'd1,
        DST_X    = 3'd2,
        DST_Y    = 3'd3,
        DST_SP   = 3'd4,
        DST_PAIR = 3'd5
    } dst_e;

    typedef enum logic [2:0] {
        SRC_IMM  = 3'd0,
        SRC_A    = 3'd1,
        SRC_X    = 3'd2,
        SRC_Y    = 3'd3,
        SRC_SP   = 3'd4,
        SRC_WORD = 3'd5
    } src_e;

    typedef struct packed {
        dst_e             dst;
        src_e             src;
        logic             flag_en;
        logic [CYC_W-1:0] cycles;
    } ctrl_t;

    // Unused codes fold onto the idle operation.
    function automatic op_e to_op(input logic [OP_W-1:0] code);
        if (code > OP_PAIR_WR) return OP_NOP;
        return op_e'(code);
    endfunction

endpackage

// File: rtl/acc_idx_decode.sv
module acc_idx_decode
    import acc_idx_pkg::*;
#(
    parameter int LOAD_CYC = 2,
    parameter int XFER_CYC = 2,
    parameter int PAIR_CYC = 2,
    parameter int NOP_CYC  = 1
) (
    input  logic [OP_W-1:0] op_code,
    output ctrl_t           ctrl
);

    localparam logic [CYC_W-1:0] C_LOAD = CYC_W'(LOAD_CYC);
    localparam logic [CYC_W-1:0] C_XFER = CYC_W'(XFER_CYC);
    localparam logic [CYC_W-1:0] C_PAIR = CYC_W'(PAIR_CYC);
    localparam logic [CYC_W-1:0] C_NOP  = CYC_W'(NOP_CYC);

    always_comb begin
        ctrl = '{dst: DST_NONE, src: SRC_IMM, flag_en: 1'b0, cycles: C_NOP};
        case (to_op(op_code))
            OP_LDI_A:   ctrl = '{dst: DST_A,    src: SRC_IMM,  flag_en: 1'b1, cycles: C_LOAD};
            OP_LDI_X:   ctrl = '{dst: DST_X,    src: SRC_IMM,  flag_en: 1'b1, cycles: C_LOAD};
            OP_LDI_Y:   ctrl = '{dst: DST_Y,    src: SRC_IMM,  flag_en: 1'b1, cycles: C_LOAD};
            OP_A_X:     ctrl = '{dst: DST_A,    src: SRC_X,    flag_en: 1'b1, cycles: C_XFER};
            OP_A_Y:     ctrl = '{dst: DST_A,    src: SRC_Y,    flag_en: 1'b1, cycles: C_XFER};
            OP_X_A:     ctrl = '{dst: DST_X,    src: SRC_A,    flag_en: 1'b1, cycles: C_XFER};
            OP_Y_A:     ctrl = '{dst: DST_Y,    src: SRC_A,    flag_en: 1'b1, cycles: C_XFER};
            OP_X_SP:    ctrl = '{dst: DST_X,    src: SRC_SP,   flag_en: 1'b1, cycles: C_XFER};
            OP_SP_X:    ctrl = '{dst: DST_SP,   src: SRC_X,    flag_en: 1'b0, cycles: C_XFER};
            OP_PAIR_WR: ctrl = '{dst: DST_PAIR, src: SRC_WORD, flag_en: 1'b1, cycles: C_PAIR};
            default:    ;
        endcase
    end

endmodule

// File: rtl/acc_idx_bank.sv
module acc_idx_bank
    import acc_idx_pkg::*;
#(
    parameter int             DW      = 8,
    parameter logic [DW-1:0]  SP_INIT = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  dst_e            dst,
    input  src_e            src,
    input  logic [DW-1:0]   imm,
    input  logic [2*DW-1:0] word,
    output logic [DW-1:0]   a,
    output logic [DW-1:0]   x,
    output logic [DW-1:0]   y,
    output logic [DW-1:0]   sp,
    output logic [DW-1:0]   res8
);

    localparam int NREG   = 4;
    localparam int IDX_A  = 0;
    localparam int IDX_X  = 1;
    localparam int IDX_Y  = 2;
    localparam int IDX_SP = 3;

    logic [NREG-1:0][DW-1:0] rq;

    assign a  = rq[IDX_A];
    assign x  = rq[IDX_X];
    assign y  = rq[IDX_Y];
    assign sp = rq[IDX_SP];

    always_comb begin
        case (src)
            SRC_IMM: res8 = imm;
            SRC_A:   res8 = rq[IDX_A];
            SRC_X:   res8 = rq[IDX_X];
            SRC_Y:   res8 = rq[IDX_Y];
            SRC_SP:  res8 = rq[IDX_SP];
            default: res8 = word[DW-1:0];
        endcase
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DW-1:0] RST_V  = (i == IDX_SP) ? SP_INIT : '0;
        localparam bit            IN_PAIR = (i == IDX_A) || (i == IDX_Y);
        logic          hit;
        logic [DW-1:0] nxt;
        logic [DW-1:0] q;

        always_comb begin
            hit = wr_en && ((dst == dst_e'(3'(i + 1))) || (IN_PAIR && dst == DST_PAIR));
            if (dst == DST_PAIR)
                nxt = (i == IDX_Y) ? word[2*DW-1:DW] : word[DW-1:0];
            else
                nxt = res8;
        end

        always_ff @(posedge clk) begin
            if (rst)      q <= RST_V;
            else if (hit) q <= nxt;
        end

        assign rq[i] = q;
    end

endmodule

// File: rtl/acc_idx_seq.sv
module acc_idx_seq
    import acc_idx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CYC_W-1:0] cyc_req,
    output logic             accept,
    output logic             busy,
    output logic             done,
    output logic [CYC_W-1:0] cyc_q
);

    logic [CYC_W-1:0] remain;

    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            remain <= '0;
            cyc_q  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy   <= 1'b1;
                remain <= cyc_req - CYC_W'(1);
                cyc_q  <= cyc_req;
            end else if (busy) begin
                if (remain == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    remain <= remain - CYC_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/acc_idx_regs.sv
module acc_idx_regs
    import acc_idx_pkg::*;
#(
    parameter int            DW       = 8,
    parameter logic [DW-1:0] SP_INIT  = '1,
    parameter int            LOAD_CYC = 2,
    parameter int            XFER_CYC = 2,
    parameter int            PAIR_CYC = 2,
    parameter int            NOP_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [OP_W-1:0]  op,
    input  logic [DW-1:0]    imm,
    input  logic [2*DW-1:0]  word_in,
    output logic [DW-1:0]    reg_a,
    output logic [DW-1:0]    reg_x,
    output logic [DW-1:0]    reg_y,
    output logic [DW-1:0]    reg_sp,
    output logic [2*DW-1:0]  pair_ya,
    output logic             busy,
    output logic             done,
    output logic [CYC_W-1:0] cycles_out,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_we
);

    ctrl_t         ctrl;
    logic          accept;
    logic [DW-1:0] res8;
    logic          n_nx;
    logic          z_nx;
    logic          fen_q;

    acc_idx_decode #(
        .LOAD_CYC (LOAD_CYC),
        .XFER_CYC (XFER_CYC),
        .PAIR_CYC (PAIR_CYC),
        .NOP_CYC  (NOP_CYC)
    ) u_dec (
        .op_code (op),
        .ctrl    (ctrl)
    );

    acc_idx_bank #(
        .DW      (DW),
        .SP_INIT (SP_INIT)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (accept),
        .dst   (ctrl.dst),
        .src   (ctrl.src),
        .imm   (imm),
        .word  (word_in),
        .a     (reg_a),
        .x     (reg_x),
        .y     (reg_y),
        .sp    (reg_sp),
        .res8  (res8)
    );

    acc_idx_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cyc_req (ctrl.cycles),
        .accept  (accept),
        .busy    (busy),
        .done    (done),
        .cyc_q   (cycles_out)
    );

    always_comb begin
        if (ctrl.dst == DST_PAIR) begin
            n_nx = word_in[2*DW-1];
            z_nx = (word_in == '0);
        end else begin
            n_nx = res8[DW-1];
            z_nx = (res8 == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            fen_q  <= 1'b0;
        end else if (accept) begin
            flag_n <= n_nx;
            flag_z <= z_nx;
            fen_q  <= ctrl.flag_en;
        end
    end

    assign flag_we = done && fen_q;
    assign pair_ya = {reg_y, reg_a};

endmodule

// File: rtl/acc_idx_regs_chk.sv
module acc_idx_regs_chk
    import acc_idx_pkg::*;
#(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [OP_W-1:0] op,
    input logic [DW-1:0]   imm,
    input logic [DW-1:0]   reg_a,
    input logic [DW-1:0]   reg_x,
    input logic [DW-1:0]   reg_y,
    input logic [DW-1:0]   reg_sp,
    input logic            busy,
    input logic            done,
    input logic            flag_we
);

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(reg_a) && $stable(reg_x) && $stable(reg_y) && $stable(reg_sp))); // R8

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> $fell(busy)); // R7

    AST_NO_BUSY_DONE: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R7

    AST_FLAG_WE_IN_DONE: assert property (@(posedge clk) disable iff (rst)
        flag_we |-> done); // R7

    AST_SP_FROM_X: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == OP_SP_X) |=> (reg_sp == $past(reg_x))); // R4

    AST_LOAD_A: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == OP_LDI_A) |=> (reg_a == $past(imm))); // R2

endmodule

bind acc_idx_regs acc_idx_regs_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op      (op),
    .imm     (imm),
    .reg_a   (reg_a),
    .reg_x   (reg_x),
    .reg_y   (reg_y),
    .reg_sp  (reg_sp),
    .busy    (busy),
    .done    (done),
    .flag_we (flag_we)
);

// File: tb/acc_idx_regs_test.sv
module acc_idx_regs_test;
    import acc_idx_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [7:0]  imm = 8'd0;
    logic [15:0] word_in = 16'd0;
    logic [7:0]  reg_a, reg_x, reg_y, reg_sp;
    logic [15:0] pair_ya;
    logic        busy, done, flag_n, flag_z, flag_we;
    logic [3:0]  cycles_out;

    int checks = 0;
    int errors = 0;
    int busy_cnt = 0;
    int cyc_total = 0;

    typedef struct {
        logic [7:0] a, x, y, sp;
        logic       n, z, fwe;
        int         cyc;
        string      tag;
    } exp_t;

    exp_t sb[$];
    logic [7:0] ma = 8'h00, mx = 8'h00, my = 8'h00, msp = 8'hFF;

    always #10 clk = ~clk;

    acc_idx_regs uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .imm(imm), .word_in(word_in),
        .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .pair_ya(pair_ya),
        .busy(busy), .done(done), .cycles_out(cycles_out),
        .flag_n(flag_n), .flag_z(flag_z), .flag_we(flag_we)
    );

    task automatic chk(input bit ok, input string what, input string act, input string expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s", what, act, expv);
        end
    endtask

    // Driver: models the expected result, queues it, then drives the request.
    task automatic issue(input logic [3:0] code, input logic [7:0] v, input logic [15:0] w,
                         input string tag, input bit intrude);
        exp_t e;
        logic [7:0] r;
        r = 8'h00;
        e.fwe = 1'b1;
        e.cyc = 2;
        e.tag = tag;
        case (code)
            4'd1:  begin ma = v;   r = v;   end
            4'd2:  begin mx = v;   r = v;   end
            4'd3:  begin my = v;   r = v;   end
            4'd4:  begin ma = mx;  r = mx;  end
            4'd5:  begin ma = my;  r = my;  end
            4'd6:  begin mx = ma;  r = ma;  end
            4'd7:  begin my = ma;  r = ma;  end
            4'd8:  begin mx = msp; r = msp; end
            4'd9:  begin msp = mx; e.fwe = 1'b0; end
            4'd10: begin ma = w[7:0]; my = w[15:8]; end
            default: begin e.fwe = 1'b0; e.cyc = 1; end
        endcase
        if (code == 4'd10) begin
            e.n = w[15];
            e.z = (w == 16'h0000);
        end else begin
            e.n = r[7];
            e.z = (r == 8'h00);
        end
        e.a = ma; e.x = mx; e.y = my; e.sp = msp;
        sb.push_back(e);

        @(negedge clk);
        start = 1'b1; op = code; imm = v; word_in = w;
        @(negedge clk);
        if (intrude) begin
            op = 4'd1; imm = 8'h55; word_in = 16'hFFFF;
            @(negedge clk);
        end
        start = 1'b0;
        while (!done) @(negedge clk);
    endtask

    // Monitor: counts busy cycles, compares at each done pulse.
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cnt++;
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R7 unexpected done", "done", "none");
                end else begin
                    exp_t e;
                    bit ok;
                    e = sb.pop_front();
                    ok = (reg_a == e.a) && (reg_x == e.x) && (reg_y == e.y) && (reg_sp == e.sp)
                         && (pair_ya == {e.y, e.a}) && (flag_we == e.fwe)
                         && (!e.fwe || (flag_n == e.n && flag_z == e.z));
                    chk(ok, {e.tag, " regs/flags"},
                        $sformatf("a=%h x=%h y=%h sp=%h ya=%h we=%b n=%b z=%b",
                                  reg_a, reg_x, reg_y, reg_sp, pair_ya, flag_we, flag_n, flag_z),
                        $sformatf("a=%h x=%h y=%h sp=%h ya=%h we=%b n=%b z=%b",
                                  e.a, e.x, e.y, e.sp, {e.y, e.a}, e.fwe, e.n, e.z));
                    chk(busy_cnt == e.cyc && int'(cycles_out) == e.cyc, {e.tag, " R7 cycles"},
                        $sformatf("busy=%0d cycles_out=%0d", busy_cnt, cycles_out),
                        $sformatf("%0d", e.cyc));
                end
                busy_cnt = 0;
            end
        end
    end

    always @(negedge clk) begin
        cyc_total++;
        if (cyc_total > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while held in reset
        chk(reg_a == 8'h00 && reg_x == 8'h00 && reg_y == 8'h00, "R1 data regs in reset",
            $sformatf("%h %h %h", reg_a, reg_x, reg_y), "00 00 00");
        chk(reg_sp == 8'hFF, "R1 sp in reset", $sformatf("%h", reg_sp), "ff");
        chk(!busy && !done, "R1 handshake in reset", $sformatf("%b%b", busy, done), "00");
        rst = 1'b0;
        @(negedge clk);
        chk(reg_a == 8'h00 && reg_sp == 8'hFF && !busy && !done, "R1 after release",
            $sformatf("a=%h sp=%h b=%b d=%b", reg_a, reg_sp, busy, done), "a=00 sp=ff b=0 d=0");

        issue(4'd1, 8'h80, 16'h0, "R2 R5 load A neg", 1'b0);
        issue(4'd2, 8'h00, 16'h0, "R2 R5 load X zero", 1'b0);
        issue(4'd3, 8'h7F, 16'h0, "R2 load Y pos", 1'b0);
        issue(4'd4, 8'h00, 16'h0, "R3 A from X", 1'b0);
        issue(4'd5, 8'h00, 16'h0, "R3 A from Y", 1'b0);
        issue(4'd6, 8'h00, 16'h0, "R3 X from A", 1'b0);
        issue(4'd1, 8'hC3, 16'h0, "R2 load A", 1'b0);
        issue(4'd7, 8'h00, 16'h0, "R3 Y from A", 1'b0);
        issue(4'd8, 8'h00, 16'h0, "R3 X from SP", 1'b0);
        issue(4'd2, 8'h10, 16'h0, "R2 load X", 1'b0);
        issue(4'd9, 8'h00, 16'h0, "R4 SP from X", 1'b0);
        issue(4'd8, 8'h00, 16'h0, "R3 X from new SP", 1'b0);
        issue(4'd10, 8'h00, 16'h8001, "R6 pair write", 1'b0);
        issue(4'd10, 8'h00, 16'h0000, "R6 pair zero", 1'b0);
        issue(4'd0, 8'hAA, 16'h0, "R9 idle", 1'b0);
        issue(4'd13, 8'hAA, 16'h1234, "R9 undefined", 1'b0);
        issue(4'd5, 8'h00, 16'h0, "R8 busy intrusion", 1'b1);

        repeat (3) @(negedge clk);
        // R8: intruding strobe must not start a later operation
        chk(!busy && !done && reg_a == ma, "R8 no late op",
            $sformatf("b=%b d=%b a=%h", busy, done, reg_a), $sformatf("b=0 d=0 a=%h", ma));
        chk(sb.size() == 0, "R7 queue drained", $sformatf("%0d", sb.size()), "0");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule